// File: doc/BRIEF.md
# Dual-Channel Bus-Hold DMA Controller

This block moves bytes from one external memory location to another without the processor. Software, or a wrapper, loads a channel with a source address, a destination address, a byte count and two increment flags through a single load strobe. The channel then asks for the external bus with a hold request. It runs its first bus cycle only once the bus owner returns the acknowledge.

Each byte takes two bus cycles: a read from the source into an internal holding register, then a write of that byte to the destination. The bus is multiplexed. Each bus cycle opens with an address strobe, while the low address byte is on the shared data lines and the high byte is on a separate address port. Read and write are separate active-low strobes. Two channels share one bus engine. Channel 0 wins whenever both are pending, and the bus engine picks a channel again only between bytes.

Top module: `dual_dma_ctrl`

## Requirements
- R1: While rst_ni is low: hold_o and ale_o are low, rd_no and wr_no are high, ad_oe_o is low, and ch_busy_o and ch_done_o are zero.
- R2: A cycle with cfg_we_i high loads the channel chosen by cfg_ch_i with its source, destination, count and increment flags, and sets that channel's ch_busy_o bit on the next cycle. A load aimed at a channel whose busy bit is set has no effect on that channel's transfer.
- R3: hold_o is high whenever a channel is busy or a byte is in flight. No address strobe starts unless hlda_i was high at the clock edge that begins it.
- R4: A byte takes four bus cycles in this order:
  - ale_o high, with the source low byte on ad_o and the source high byte on addr_hi_o;
  - rd_no low for one cycle, with ad_oe_o low and the source high byte held on addr_hi_o;
  - ale_o high, with the destination address presented the same way;
  - wr_no low for one cycle, with the byte read in the second cycle on ad_o and ad_oe_o high.
  rd_no and wr_no are never low together.
- R5: After each byte the source address and the destination address each add one when their own increment flag is set, and otherwise stay fixed. Both wrap modulo 2^ADDR_W.
- R6: A loaded count N moves exactly N bytes for N from 1 to 2^CNT_W-1. A count of zero moves 2^CNT_W bytes.
- R7: When the last byte's write cycle ends, the channel's busy bit clears and its ch_done_o bit is high for exactly one cycle. hold_o is low in that cycle unless the other channel is busy.
- R8: When both channels are busy, channel 0 is granted at every byte boundary. A pending channel 1 therefore starts only after channel 0 has finished.
- R9: If hlda_i falls during a byte, the bus cycle already running completes. No further address strobe follows until hlda_i is high again, and the transfer then resumes with no byte lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load strobe for the channel chosen by cfg_ch_i |
| cfg_ch_i | input | CH_W | Channel index for the load |
| cfg_src_i | input | ADDR_W | Source start address |
| cfg_dst_i | input | ADDR_W | Destination start address |
| cfg_cnt_i | input | CNT_W | Byte count, zero meaning 2^CNT_W |
| cfg_src_inc_i | input | 1 | Step the source address after each byte |
| cfg_dst_inc_i | input | 1 | Step the destination address after each byte |
| ch_busy_o | output | NUM_CH | Channel is loaded and not finished |
| ch_done_o | output | NUM_CH | One-cycle pulse at the end of a channel's transfer |
| hold_o | output | 1 | Bus request |
| hlda_i | input | 1 | Bus grant |
| ale_o | output | 1 | Address strobe for the multiplexed bus |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| ad_o | output | DATA_W | Address low byte or write data |
| ad_i | input | DATA_W | Read data from the bus |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| addr_hi_o | output | ADDR_W-DATA_W | Upper address byte |

## Verification
The bench sweeps all four combinations of increment flags across several counts. It checks both the final memory image and the exact sequence of strobed addresses, so a source and destination that were swapped, or an increment that went to the wrong pointer, would show up as a wrong address in the log. A source address that runs past the top of the space must wrap to zero, and a count of zero must move the full 2^CNT_W bytes instead of none. A design that stops one byte early or late, or that treats zero as nothing to do, fails the read and write strobe totals.

With acknowledge withheld, no strobe may appear. When acknowledge drops inside a read, the bench expects exactly one completed read and then no strobes at all until acknowledge returns. A design that aborts the read, or that carries on into the write, breaks those counts. With both channels loaded, any interleaving or any start by channel 1 ahead of channel 0 puts the address log out of order. A load aimed at a running channel must leave that transfer intact.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    BS_IDLE,
    BS_RADDR,
    BS_READ,
    BS_WGAP,
    BS_WADDR,
    BS_WRITE
  } bus_state_e;
endpackage

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              src_inc_i,
  input  logic              dst_inc_i,
  input  logic              step_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sinc_q, dinc_q, busy_q, done_q;
  logic              last_byte;

  // count of zero wraps through all values: 2^CNT_W bytes
  assign last_byte = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      sinc_q <= 1'b0;
      dinc_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= step_i && busy_q && last_byte;
      if (load_i && !busy_q) begin
        src_q  <= src_i;
        dst_q  <= dst_i;
        cnt_q  <= cnt_i;
        sinc_q <= src_inc_i;
        dinc_q <= dst_inc_i;
        busy_q <= 1'b1;
      end else if (step_i && busy_q) begin
        if (sinc_q) src_q <= src_q + ADDR_W'(1);
        if (dinc_q) dst_q <= dst_q + ADDR_W'(1);
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_byte) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;

  p_step_when_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> busy_q);
  p_done_not_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  p_load_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && busy_q && !step_i) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));
  p_src_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && busy_q && sinc_q) |=> (src_q == $past(src_q) + ADDR_W'(1)));
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  output logic              any_o,
  output logic [CH_W-1:0]   idx_o
);
  logic [NUM_CH-1:0] grant;
  logic              found;

  // lowest index wins
  always_comb begin
    grant = '0;
    idx_o = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req_i[i] && !found) begin
        grant[i] = 1'b1;
        idx_o    = CH_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign any_o = |req_i;

  p_grant_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  p_ch0_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> (grant[0] && idx_o == '0));
endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CH_W   = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_any_i,
  input  logic [CH_W-1:0]          grant_idx_i,
  input  logic                     hlda_i,
  input  logic [ADDR_W-1:0]        src_i,
  input  logic [ADDR_W-1:0]        dst_i,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [CH_W-1:0]          sel_o,
  output logic                     active_o,
  output logic                     step_o,
  output logic                     ale_o,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o
);
  bus_state_e        state_q, state_d;
  logic [CH_W-1:0]   sel_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BS_IDLE:  if (req_any_i && hlda_i) state_d = BS_RADDR;
      BS_RADDR: state_d = BS_READ;
      BS_READ:  state_d = hlda_i ? BS_WADDR : BS_WGAP;
      BS_WGAP:  if (hlda_i) state_d = BS_WADDR;
      BS_WADDR: state_d = BS_WRITE;
      BS_WRITE: state_d = BS_IDLE;
      default:  state_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BS_IDLE;
      sel_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == BS_IDLE) sel_q <= grant_idx_i;
      if (state_q == BS_READ) data_q <= ad_i;
    end
  end

  always_comb begin
    ale_o     = 1'b0;
    rd_no     = 1'b1;
    wr_no     = 1'b1;
    ad_o      = '0;
    ad_oe_o   = 1'b0;
    addr_hi_o = '0;
    unique case (state_q)
      BS_RADDR: begin
        ale_o     = 1'b1;
        ad_oe_o   = 1'b1;
        ad_o      = src_i[DATA_W-1:0];
        addr_hi_o = src_i[ADDR_W-1:DATA_W];
      end
      BS_READ: begin
        rd_no     = 1'b0;
        addr_hi_o = src_i[ADDR_W-1:DATA_W];
      end
      BS_WADDR: begin
        ale_o     = 1'b1;
        ad_oe_o   = 1'b1;
        ad_o      = dst_i[DATA_W-1:0];
        addr_hi_o = dst_i[ADDR_W-1:DATA_W];
      end
      BS_WRITE: begin
        wr_no     = 1'b0;
        ad_oe_o   = 1'b1;
        ad_o      = data_q;
        addr_hi_o = dst_i[ADDR_W-1:DATA_W];
      end
      default: ;
    endcase
  end

  assign sel_o    = sel_q;
  assign active_o = (state_q != BS_IDLE);
  assign step_o   = (state_q == BS_WRITE);

  p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  p_read_after_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BS_RADDR) |=> !rd_no);
  p_write_after_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BS_WADDR) |=> (!wr_no && ad_oe_o));
  p_idle_waits_hlda_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BS_IDLE && !hlda_i) |=> !ale_o);
  p_gap_waits_hlda_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BS_WGAP && !hlda_i) |=> (state_q == BS_WGAP));
  p_sel_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != BS_IDLE) |=> (state_q == BS_IDLE || $stable(sel_q)));
endmodule

// File: rtl/dual_dma_ctrl.sv
module dual_dma_ctrl #(
  parameter int  ADDR_W = 16,
  parameter int  DATA_W = 8,
  parameter int  CNT_W  = 16,
  parameter int  NUM_CH = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [CH_W-1:0]          cfg_ch_i,
  input  logic [ADDR_W-1:0]        cfg_src_i,
  input  logic [ADDR_W-1:0]        cfg_dst_i,
  input  logic [CNT_W-1:0]         cfg_cnt_i,
  input  logic                     cfg_src_inc_i,
  input  logic                     cfg_dst_inc_i,
  output logic [NUM_CH-1:0]        ch_busy_o,
  output logic [NUM_CH-1:0]        ch_done_o,
  output logic                     hold_o,
  input  logic                     hlda_i,
  output logic                     ale_o,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic [DATA_W-1:0]        ad_o,
  input  logic [DATA_W-1:0]        ad_i,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o
);
  logic [ADDR_W-1:0] src_arr [NUM_CH];
  logic [ADDR_W-1:0] dst_arr [NUM_CH];
  logic [NUM_CH-1:0] busy, done;
  logic [CH_W-1:0]   grant_idx, sel;
  logic              req_any, active, step;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (cfg_we_i && (cfg_ch_i == CH_W'(c))),
      .src_i     (cfg_src_i),
      .dst_i     (cfg_dst_i),
      .cnt_i     (cfg_cnt_i),
      .src_inc_i (cfg_src_inc_i),
      .dst_inc_i (cfg_dst_inc_i),
      .step_i    (step && (sel == CH_W'(c))),
      .busy_o    (busy[c]),
      .done_o    (done[c]),
      .src_o     (src_arr[c]),
      .dst_o     (dst_arr[c])
    );
  end

  dma_arbiter #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (busy),
    .any_o  (req_any),
    .idx_o  (grant_idx)
  );

  dma_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_any_i   (req_any),
    .grant_idx_i (grant_idx),
    .hlda_i      (hlda_i),
    .src_i       (src_arr[sel]),
    .dst_i       (dst_arr[sel]),
    .ad_i        (ad_i),
    .sel_o       (sel),
    .active_o    (active),
    .step_o      (step),
    .ale_o       (ale_o),
    .rd_no       (rd_no),
    .wr_no       (wr_no),
    .ad_o        (ad_o),
    .ad_oe_o     (ad_oe_o),
    .addr_hi_o   (addr_hi_o)
  );

  assign hold_o    = req_any || active;
  assign ch_busy_o = busy;
  assign ch_done_o = done;

  p_hold_covers_bus_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no || ale_o) |-> hold_o);
  p_done_releases_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|done) && !(|busy)) |-> !hold_o);
endmodule

// File: tb/test_dual_dma_ctrl.sv
`timescale 1ns/1ps
module test_dual_dma_ctrl;
  localparam int CNT_W = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_ch = '0;
  logic [15:0] cfg_src = '0, cfg_dst = '0;
  logic [CNT_W-1:0] cfg_cnt = '0;
  logic        cfg_si = 1'b0, cfg_di = 1'b0;
  logic [1:0]  busy, done;
  logic        hold_o, hlda = 1'b0, ale_o, rd_no, wr_no, ad_oe_o;
  logic [7:0]  ad_o, ad_i, addr_hi_o;

  always #2 clk = ~clk;

  dual_dma_ctrl #(.ADDR_W(16), .DATA_W(8), .CNT_W(CNT_W), .NUM_CH(2)) i_dual_dma_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_src_i(cfg_src), .cfg_dst_i(cfg_dst), .cfg_cnt_i(cfg_cnt),
    .cfg_src_inc_i(cfg_si), .cfg_dst_inc_i(cfg_di), .ch_busy_o(busy), .ch_done_o(done),
    .hold_o(hold_o), .hlda_i(hlda), .ale_o(ale_o), .rd_no(rd_no), .wr_no(wr_no),
    .ad_o(ad_o), .ad_i(ad_i), .ad_oe_o(ad_oe_o), .addr_hi_o(addr_hi_o)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) ^ (i >> 4));
  endfunction

  // bus model and monitor, all at the falling edge
  logic [7:0]  mem [1024];
  logic [15:0] log_addr [1024];
  logic [15:0] cur_addr = '0;
  int  log_cnt = 0, rd_cnt = 0, wr_cnt = 0, r3_viol = 0, r4_viol = 0;
  int  done_cnt [2] = '{0, 0};
  logic hold_at_done [2] = '{1'b0, 1'b0};
  logic hlda_prev = 1'b0;
  bit  mem_ready = 1'b0, drop_req = 1'b0, drop_arm = 1'b0;
  int  drop_at = -1;

  assign ad_i = mem[cur_addr[9:0]];

  always @(negedge clk) begin
    if (!mem_ready) begin
      for (int i = 0; i < 1024; i++) mem[i] = pat(i);
      mem_ready = 1'b1;
    end
    if (rst_n) begin
      if (!rd_no && !wr_no) r4_viol++;
      if (ale_o) begin
        if (!hlda_prev) r3_viol++;
        if (drop_arm && log_cnt == drop_at) drop_req = 1'b1;
        cur_addr = {addr_hi_o, ad_o};
        log_addr[log_cnt] = cur_addr;
        log_cnt++;
      end
      if (!rd_no) begin
        rd_cnt++;
        if (addr_hi_o != cur_addr[15:8] || ad_oe_o) r4_viol++;
      end
      if (!wr_no) begin
        wr_cnt++;
        if (addr_hi_o != cur_addr[15:8] || !ad_oe_o) r4_viol++;
        mem[cur_addr[9:0]] = ad_o;
      end
      for (int c = 0; c < 2; c++)
        if (done[c]) begin
          done_cnt[c]++;
          hold_at_done[c] = hold_o;
        end
    end
    hlda_prev = hlda;
  end

  int checks = 0, failures = 0;
  logic [7:0]  exp_mem [1024];
  logic [15:0] exp_log [1024];
  int exp_n = 0, log_base = 0, rd_base = 0, wr_base = 0;
  int exp_done [2] = '{0, 0};

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic prog(int ch, logic [15:0] s, logic [15:0] d, int n, bit si, bit di);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_ch = 1'(ch); cfg_src = s; cfg_dst = d;
    cfg_cnt = CNT_W'(n); cfg_si = si; cfg_di = di;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic model(logic [15:0] s, logic [15:0] d, int n, bit si, bit di);
    for (int k = 0; k < n; k++) begin
      logic [15:0] sa, da;
      sa = s + (si ? 16'(k) : 16'd0);
      da = d + (di ? 16'(k) : 16'd0);
      exp_mem[da[9:0]] = exp_mem[sa[9:0]];
      exp_log[exp_n] = sa; exp_log[exp_n + 1] = da;
      exp_n += 2;
    end
  endtask

  task automatic start_test();
    log_base = log_cnt; rd_base = rd_cnt; wr_base = wr_cnt; exp_n = 0;
  endtask

  task automatic wait_done(int ch);
    for (int t = 0; t < 5000 && done_cnt[ch] < exp_done[ch]; t++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic verify(string req, int nbytes);
    int bad, first;
    bad = 0; first = -1;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== exp_mem[i]) begin bad++; if (first < 0) first = i; end
    check(bad == 0, req, "memory mismatches (first idx below)", bad, 0);
    if (bad != 0) $display("  first bad idx %0d", first);
    check(log_cnt - log_base == exp_n, req, "address strobes", log_cnt - log_base, exp_n);
    bad = 0;
    for (int i = 0; i < exp_n && i < log_cnt - log_base; i++)
      if (log_addr[log_base + i] !== exp_log[i]) bad++;
    check(bad == 0, req, "strobed address order errors", bad, 0);
    check(rd_cnt - rd_base == nbytes, "R6", "read strobes", rd_cnt - rd_base, nbytes);
    check(wr_cnt - wr_base == nbytes, "R6", "write strobes", wr_cnt - wr_base, nbytes);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) exp_mem[i] = pat(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(hold_o == 0 && rd_no == 1 && wr_no == 1 && ale_o == 0 && ad_oe_o == 0
          && busy == 0 && done == 0, "R1", "reset outputs",
          {hold_o, rd_no, wr_no, ale_o, ad_oe_o, busy, done}, 7'b0110000);
    @(posedge clk); #1;
    rst_n = 1'b1; hlda = 1'b1;

    // R4 R5 R6 R7: sweep of increment modes and counts on channel 0
    for (int m = 0; m < 4; m++) begin
      for (int ci = 0; ci < 3; ci++) begin
        int n;
        logic [15:0] s, d;
        n = (ci == 0) ? 1 : (ci == 1) ? 3 : 7;
        s = 16'h0310 + 16'(m * 16);
        d = 16'h0140 + 16'(m * 32);
        start_test();
        model(s, d, n, m[0], m[1]);
        exp_done[0]++;
        prog(0, s, d, n, m[0], m[1]);
        wait_done(0);
        check(done_cnt[0] == exp_done[0], "R7", "done pulses ch0", done_cnt[0], exp_done[0]);
        check(busy[0] == 0, "R7", "busy after done", busy[0], 0);
        check(hold_at_done[0] == 0, "R7", "hold during done", hold_at_done[0], 0);
        verify("R5", n);
      end
    end

    // R5 wrap of the source address past the top of the space
    start_test();
    model(16'hFFFE, 16'h0201, 4, 1'b1, 1'b1);
    exp_done[0]++;
    prog(0, 16'hFFFE, 16'h0201, 4, 1'b1, 1'b1);
    wait_done(0);
    verify("R5", 4);

    // R6 zero count moves 2^CNT_W bytes
    start_test();
    model(16'h0000, 16'h0280, 64, 1'b1, 1'b1);
    exp_done[0]++;
    prog(0, 16'h0000, 16'h0280, 0, 1'b1, 1'b1);
    wait_done(0);
    check(done_cnt[0] == exp_done[0], "R6", "zero count done", done_cnt[0], exp_done[0]);
    verify("R6", 64);

    // R2 load and ignored reload of a busy channel
    start_test();
    model(16'h0050, 16'h0060, 7, 1'b1, 1'b1);
    exp_done[0]++;
    prog(0, 16'h0050, 16'h0060, 7, 1'b1, 1'b1);
    @(negedge clk);
    check(busy[0] == 1, "R2", "busy after load", busy[0], 1);
    repeat (6) @(posedge clk);
    prog(0, 16'h0090, 16'h00A0, 2, 1'b0, 1'b0);
    wait_done(0);
    check(done_cnt[0] == exp_done[0], "R2", "one done despite reload", done_cnt[0], exp_done[0]);
    verify("R2", 7);

    // R3 no bus activity while acknowledge is withheld
    @(posedge clk); #1; hlda = 1'b0;
    start_test();
    model(16'h0070, 16'h0078, 2, 1'b1, 1'b1);
    exp_done[1]++;
    prog(1, 16'h0070, 16'h0078, 2, 1'b1, 1'b1);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(hold_o == 1, "R3", "hold while waiting", hold_o, 1);
    check(log_cnt == log_base, "R3", "strobes without ack", log_cnt - log_base, 0);
    @(posedge clk); #1; hlda = 1'b1;
    wait_done(1);
    check(hold_at_done[1] == 0, "R7", "hold at ch1 done", hold_at_done[1], 0);
    verify("R3", 2);

    // R8 both channels pending: channel 0 runs to completion first
    @(posedge clk); #1; hlda = 1'b0;
    start_test();
    model(16'h00D0, 16'h00E0, 3, 1'b1, 1'b1);
    model(16'h00B0, 16'h00C0, 4, 1'b1, 1'b0);
    exp_done[0]++; exp_done[1]++;
    prog(1, 16'h00B0, 16'h00C0, 4, 1'b1, 1'b0);
    prog(0, 16'h00D0, 16'h00E0, 3, 1'b1, 1'b1);
    @(posedge clk); #1; hlda = 1'b1;
    wait_done(1);
    check(done_cnt[0] == exp_done[0], "R8", "ch0 done", done_cnt[0], exp_done[0]);
    check(hold_at_done[0] == 1, "R3", "hold kept for ch1", hold_at_done[0], 1);
    verify("R8", 7);

    // R9 acknowledge removed during the second byte's read
    begin
      int lc, rc, wc;
      start_test();
      model(16'h0100, 16'h0108, 4, 1'b1, 1'b1);
      exp_done[0]++;
      drop_at = log_cnt + 2;
      drop_arm = 1'b1;
      prog(0, 16'h0100, 16'h0108, 4, 1'b1, 1'b1);
      for (int t = 0; t < 2000 && !drop_req; t++) @(posedge clk);
      #1; hlda = 1'b0;
      lc = log_cnt; rc = rd_cnt; wc = wr_cnt;
      repeat (10) @(posedge clk);
      @(negedge clk);
      check(log_cnt == lc, "R9", "strobes while ack low", log_cnt - lc, 0);
      check(rd_cnt == rc + 1, "R9", "read completed", rd_cnt - rc, 1);
      check(wr_cnt == wc, "R9", "writes while ack low", wr_cnt - wc, 0);
      check(hold_o == 1, "R9", "hold kept", hold_o, 1);
      @(posedge clk); #1; hlda = 1'b1; drop_arm = 1'b0;
      wait_done(0);
      verify("R9", 4);
    end

    check(r3_viol == 0, "R3", "strobes after ack low", r3_viol, 0);
    check(r4_viol == 0, "R4", "bus phase violations", r4_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule